// File: doc/BRIEF.md
# Receive Signal-Detect Qualifier with Hysteresis

This block produces the single signal-detect bit of a twisted-pair receiver from a digitized peak-to-peak amplitude code in millivolts. Two amplitude windows drive it. The upper window turns the indication on. The lower window turns it off. Amplitudes between the two leave the indication where it is. Before it acts, each window must hold for its own dwell time, counted in clock cycles. The surrounding logic sets each dwell time through an input port.

Two overrides sit in front of the hysteresis. A high level on the active-low cable-good input reports a wiring fault, and the block then drives the indication low. Loopback drives the indication high, and it wins over a wiring fault. While either override is active, the hysteresis state is frozen and both dwell counters stay at zero. After release, qualification starts fresh from the frozen state.

Typical dwell settings at a 125 MHz clock are 8750 cycles for the turn-on delay (70 µs) and 3750 cycles for the turn-off delay (30 µs). Both lie inside the usual windows of 40 to 100 µs for turn-on and 12 to 50 µs for turn-off.

Top module: `sigdet_qualifier`

## Requirements
- R1: While reset (rstN low) is active, and after it is released, sigDet is 0 until a qualification completes.
- R2: With no override active and sigDet low, sigDet rises at the clock edge that completes onDwell consecutive edges at which ampMv >= ON_MV (700 by default). An onDwell of 0 acts as 1.
- R3: With no override active and sigDet high, sigDet falls at the clock edge that completes offDwell consecutive edges at which ampMv <= OFF_MV (200 by default). An offDwell of 0 acts as 1.
- R4: With no override active, an amplitude strictly between OFF_MV and ON_MV never changes sigDet.
- R5: If the amplitude leaves the qualifying window before the dwell completes, the count restarts. The next qualification needs a full dwell again.
- R6: With loopEn low and cableGoodN high, sigDet is 0 from the next clock edge, whatever the amplitude.
- R7: With loopEn high, sigDet is 1 from the next clock edge, whatever the amplitude and cableGoodN.
- R8: While an override is active, the hysteresis state is frozen and its dwell counts are cleared. At the first edge after release, sigDet shows the frozen state. A transition after release needs a full dwell counted from the release.
- R9: The thresholds are inclusive. 700 counts toward turn-on and 699 does not. 200 counts toward turn-off and 201 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| ampMv | input | AMP_W (12) | Received peak-to-peak amplitude code, mV |
| loopEn | input | 1 | Loopback active; forces sigDet high |
| cableGoodN | input | 1 | Active-low cable-good; high forces sigDet low |
| onDwell | input | CNT_W (16) | Turn-on dwell, clock edges |
| offDwell | input | CNT_W (16) | Turn-off dwell, clock edges |
| sigDet | output | 1 | Qualified signal-detect indication |

## Verification
On every cycle, the bound checker enforces the following. Both overrides take effect one edge later, with loopback taking priority. The hysteresis state never moves while an override is active. It never moves on a mid-band amplitude. Each rising and falling transition of the state follows an amplitude inside the matching window. Only the bench scenarios can show the exact dwell lengths. The bench measures these by sweeping both dwell settings over small values, including zero. It also covers the restart of a count after an interrupted qualification, the inclusive threshold boundaries, and the full re-qualification after an override is released.

// File: rtl/sdq_pkg.sv
package sdq_pkg;

  // Strobes issued by the control to the dwell datapath.
  typedef struct packed {
    logic onClr;
    logic onInc;
    logic offClr;
    logic offInc;
  } sdq_strobe_t;

  // Conditions reported by the datapath back to the control.
  typedef struct packed {
    logic aboveOn;
    logic belowOff;
    logic onDone;
    logic offDone;
  } sdq_status_t;

endpackage

// File: rtl/sdq_dwell_counter.sv
module sdq_dwell_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             inc,
  input  logic             qual,
  input  logic [CNT_W-1:0] dwell,
  output logic             done
);

  localparam logic [CNT_W:0] ONE = {{CNT_W{1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cntInc;

  // The count after this edge is compared with the target.
  // A target of zero is therefore reached on the first qualifying edge.
  assign cntInc = {1'b0, cnt} + ONE;
  assign done   = qual && (cntInc >= {1'b0, dwell});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cntInc[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/sdq_datapath.sv
module sdq_datapath
  import sdq_pkg::*;
#(
  parameter int AMP_W  = 12,
  parameter int CNT_W  = 16,
  parameter int ON_MV  = 700,
  parameter int OFF_MV = 200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AMP_W-1:0] ampMv,
  input  logic [CNT_W-1:0] onDwell,
  input  logic [CNT_W-1:0] offDwell,
  input  sdq_strobe_t      strobe,
  output sdq_status_t      status
);

  localparam logic [AMP_W-1:0] ON_CODE  = AMP_W'(ON_MV);
  localparam logic [AMP_W-1:0] OFF_CODE = AMP_W'(OFF_MV);

  logic aboveOn;
  logic belowOff;
  logic onDone;
  logic offDone;

  assign aboveOn  = (ampMv >= ON_CODE);
  assign belowOff = (ampMv <= OFF_CODE);

  sdq_dwell_counter #(.CNT_W(CNT_W)) u_onCnt (
    .clk   (clk),
    .rstN  (rstN),
    .clr   (strobe.onClr),
    .inc   (strobe.onInc),
    .qual  (aboveOn),
    .dwell (onDwell),
    .done  (onDone)
  );

  sdq_dwell_counter #(.CNT_W(CNT_W)) u_offCnt (
    .clk   (clk),
    .rstN  (rstN),
    .clr   (strobe.offClr),
    .inc   (strobe.offInc),
    .qual  (belowOff),
    .dwell (offDwell),
    .done  (offDone)
  );

  always_comb begin
    status.aboveOn  = aboveOn;
    status.belowOff = belowOff;
    status.onDone   = onDone;
    status.offDone  = offDone;
  end

endmodule

// File: rtl/sdq_control.sv
module sdq_control
  import sdq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        loopEn,
  input  logic        cableGoodN,
  input  sdq_status_t status,
  output sdq_strobe_t strobe,
  output logic        hysState,
  output logic        sigDet
);

  logic override;
  logic hysNext;
  logic sigNext;

  assign override = loopEn | cableGoodN;

  always_comb begin
    strobe  = '0;
    hysNext = hysState;
    if (override) begin
      // Frozen state; both qualifications start over after release.
      strobe.onClr  = 1'b1;
      strobe.offClr = 1'b1;
    end else if (!hysState) begin
      strobe.offClr = 1'b1;
      strobe.onInc  = status.aboveOn & ~status.onDone;
      strobe.onClr  = ~status.aboveOn | status.onDone;
      if (status.onDone) hysNext = 1'b1;
    end else begin
      strobe.onClr  = 1'b1;
      strobe.offInc = status.belowOff & ~status.offDone;
      strobe.offClr = ~status.belowOff | status.offDone;
      if (status.offDone) hysNext = 1'b0;
    end
  end

  // Loopback outranks the cable fault; both outrank hysteresis.
  always_comb begin
    if (loopEn)          sigNext = 1'b1;
    else if (cableGoodN) sigNext = 1'b0;
    else                 sigNext = hysNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hysState <= 1'b0;
      sigDet   <= 1'b0;
    end else begin
      hysState <= hysNext;
      sigDet   <= sigNext;
    end
  end

endmodule

// File: rtl/sigdet_qualifier.sv
module sigdet_qualifier
  import sdq_pkg::*;
#(
  parameter int AMP_W  = 12,
  parameter int CNT_W  = 16,
  parameter int ON_MV  = 700,
  parameter int OFF_MV = 200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AMP_W-1:0] ampMv,
  input  logic             loopEn,
  input  logic             cableGoodN,
  input  logic [CNT_W-1:0] onDwell,
  input  logic [CNT_W-1:0] offDwell,
  output logic             sigDet
);

  sdq_strobe_t strobe;
  sdq_status_t status;
  logic        hysState;

  sdq_datapath #(
    .AMP_W  (AMP_W),
    .CNT_W  (CNT_W),
    .ON_MV  (ON_MV),
    .OFF_MV (OFF_MV)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ampMv    (ampMv),
    .onDwell  (onDwell),
    .offDwell (offDwell),
    .strobe   (strobe),
    .status   (status)
  );

  sdq_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .loopEn     (loopEn),
    .cableGoodN (cableGoodN),
    .status     (status),
    .strobe     (strobe),
    .hysState   (hysState),
    .sigDet     (sigDet)
  );

endmodule

// File: rtl/sdq_checker.sv
module sdq_checker #(
  parameter int AMP_W  = 12,
  parameter int ON_MV  = 700,
  parameter int OFF_MV = 200
) (
  input logic             clk,
  input logic             rstN,
  input logic [AMP_W-1:0] ampMv,
  input logic             loopEn,
  input logic             cableGoodN,
  input logic             sigDet,
  input logic             hysState
);

  localparam logic [AMP_W-1:0] ON_CODE  = AMP_W'(ON_MV);
  localparam logic [AMP_W-1:0] OFF_CODE = AMP_W'(OFF_MV);

  a_r1_reset_low: assert property (@(posedge clk)
    !rstN |=> (!sigDet && !hysState));

  a_r7_loop_high: assert property (@(posedge clk) disable iff (!rstN)
    loopEn |=> sigDet);

  a_r6_fault_low: assert property (@(posedge clk) disable iff (!rstN)
    (!loopEn && cableGoodN) |=> !sigDet);

  a_r8_override_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (loopEn || cableGoodN) |=> $stable(hysState));

  a_r4_mid_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!loopEn && !cableGoodN && ampMv > OFF_CODE && ampMv < ON_CODE)
      |=> $stable(hysState));

  a_r2_rise_above: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hysState) |-> ($past(ampMv) >= ON_CODE));

  a_r3_fall_below: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hysState) |-> ($past(ampMv) <= OFF_CODE));

endmodule

bind sigdet_qualifier sdq_checker #(
  .AMP_W  (AMP_W),
  .ON_MV  (ON_MV),
  .OFF_MV (OFF_MV)
) u_sdqChk (
  .clk        (clk),
  .rstN       (rstN),
  .ampMv      (ampMv),
  .loopEn     (loopEn),
  .cableGoodN (cableGoodN),
  .sigDet     (sigDet),
  .hysState   (hysState)
);

// File: tb/sigdet_qualifier_test.sv
module sigdet_qualifier_test;

  localparam int CLK_PERIOD = 10;
  localparam int AMP_W = 12;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [AMP_W-1:0] ampMv = '0;
  logic             loopEn = 1'b0;
  logic             cableGoodN = 1'b0;
  logic [CNT_W-1:0] onDwell = 16'd3;
  logic [CNT_W-1:0] offDwell = 16'd2;
  logic             sigDet;

  int nChecks = 0;
  int nFail = 0;

  sigdet_qualifier #(.AMP_W(AMP_W), .CNT_W(CNT_W)) uut (
    .clk        (clk),
    .rstN       (rstN),
    .ampMv      (ampMv),
    .loopEn     (loopEn),
    .cableGoodN (cableGoodN),
    .onDwell    (onDwell),
    .offDwell   (offDwell),
    .sigDet     (sigDet)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic doReset();
    ampMv = '0; loopEn = 1'b0; cableGoodN = 1'b0;
    rstN = 1'b0;
    step(); step();
    rstN = 1'b1;
  endtask

  // Edges until sigDet equals target (capped at 60).
  task automatic edgesUntil(input logic target, output int n);
    n = 0;
    while (sigDet !== target && n <= 60) begin
      step();
      n++;
    end
  endtask

  // Stays at level for the given edges; returns 1 if it never moved.
  task automatic holds(input logic lvl, input int cycles, output int ok);
    ok = 1;
    for (int i = 0; i < cycles; i++) begin
      step();
      if (sigDet !== lvl) ok = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFail++;
    nChecks++;
    $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    int n;
    int ok;

    // R2/R3/R4 sweep over small dwell settings including zero
    for (int on = 0; on <= 6; on++) begin
      for (int off = 0; off <= 5; off++) begin
        onDwell = CNT_W'(on);
        offDwell = CNT_W'(off);
        doReset();
        check("R1 low after reset", sigDet, 0);
        ampMv = 12'd900;
        edgesUntil(1'b1, n);
        check("R2 turn-on edges", n, (on == 0) ? 1 : on);
        ampMv = 12'd450;
        holds(1'b1, 8, ok);
        check("R4 mid band holds high", ok, 1);
        ampMv = 12'd50;
        edgesUntil(1'b0, n);
        check("R3 turn-off edges", n, (off == 0) ? 1 : off);
        ampMv = 12'd600;
        holds(1'b0, 8, ok);
        check("R4 mid band holds low", ok, 1);
      end
    end

    // R9 inclusive thresholds
    onDwell = 16'd3; offDwell = 16'd2;
    doReset();
    ampMv = 12'd699;
    holds(1'b0, 12, ok);
    check("R9 699 does not qualify", ok, 1);
    ampMv = 12'd700;
    edgesUntil(1'b1, n);
    check("R9 700 qualifies", n, 3);
    ampMv = 12'd201;
    holds(1'b1, 12, ok);
    check("R9 201 does not qualify", ok, 1);
    ampMv = 12'd200;
    edgesUntil(1'b0, n);
    check("R9 200 qualifies", n, 2);

    // R5 restart of interrupted counts
    onDwell = 16'd4; offDwell = 16'd3;
    doReset();
    ampMv = 12'd800;
    holds(1'b0, 3, ok);
    ampMv = 12'd500;
    step();
    ampMv = 12'd800;
    edgesUntil(1'b1, n);
    check("R5 turn-on restarts", n, 4);
    ampMv = 12'd100;
    holds(1'b1, 2, ok);
    ampMv = 12'd300;
    step();
    ampMv = 12'd100;
    edgesUntil(1'b0, n);
    check("R5 turn-off restarts", n, 3);

    // R6 cable fault forces low; R8 frozen state returns on release
    ampMv = 12'd800;
    edgesUntil(1'b1, n);
    ampMv = 12'd450;
    cableGoodN = 1'b1;
    step();
    check("R6 fault forces low", sigDet, 0);
    ampMv = 12'd50;
    holds(1'b0, 10, ok);
    check("R6 fault holds low with low amp", ok, 1);
    ampMv = 12'd450;
    cableGoodN = 1'b0;
    step();
    check("R8 frozen high state restored", sigDet, 1);

    // R8 counts cleared during override: full dwell after release
    ampMv = 12'd50;
    edgesUntil(1'b0, n);
    ampMv = 12'd900;
    cableGoodN = 1'b1;
    holds(1'b0, 20, ok);
    check("R6 fault holds low with high amp", ok, 1);
    cableGoodN = 1'b0;
    edgesUntil(1'b1, n);
    check("R8 full turn-on dwell after release", n, 4);

    // R7 loopback forces high, over cable fault
    ampMv = 12'd0;
    edgesUntil(1'b0, n);
    loopEn = 1'b1;
    cableGoodN = 1'b1;
    step();
    check("R7 loopback over fault", sigDet, 1);
    cableGoodN = 1'b0;
    holds(1'b1, 10, ok);
    check("R7 loopback holds with zero amp", ok, 1);
    loopEn = 1'b0;
    step();
    check("R8 frozen low state after loopback", sigDet, 0);

    // R1 reset in the middle of operation
    ampMv = 12'd900;
    edgesUntil(1'b1, n);
    rstN = 1'b0;
    #2;
    check("R1 async reset clears output", sigDet, 0);
    step();
    rstN = 1'b1;
    edgesUntil(1'b1, n);
    check("R1 R2 qualification after reset", n, 4);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule